// File: doc/BRIEF.md
# Tiled Direct Convolution Engine

This block computes one convolution layer straight out of three on-chip memories: input feature maps, a weight array and an output (partial-sum) array. After a single-cycle start pulse, a sequencer walks a fixed seven-deep loop nest in which the output-row loop is cut into tiles of a configurable height. Each loop step produces three addresses, one each for the input pixel, the weight and the output word. A single pipelined multiply-accumulate datapath multiplies the weight by the pixel and adds the product into the output word with a read-modify-write.

The row-within-tile loop sits inside the column loop, so an output word is touched many times during one sweep: once per kernel tap, once per input map and again whenever its tile comes around. The output memory must hold zeros before start if a pure convolution is wanted. If it is left uncleared, the new sums are added to what it already holds. All layer dimensions are elaboration-time parameters. Loading the memories, padding, bias and activation are left to surrounding logic.

Top module: `conv_tile_engine`

## Requirements
- R1: While reset is asserted and after its release, `busy`, `done` and all memory enables are low.
- R2: Output writes follow this loop order, from outermost to innermost: output map `om`, input map `im`, tile start `ts` (stepping by `TR` from 0), column `c`, row `r` from `ts` up to but not including min(`R`, `ts`+`TR`), kernel row `ky`, kernel column `kx`. There is one write per step.
- R3: When `TR` does not divide `R`, the last tile is shorter. No row at or beyond `R` is ever visited.
- R4: The memories are laid out as follows. The input address is `im`·IH·IW + (S·`r`+`ky`)·IW + (S·`c`+`kx`), where IH=(R−1)·S+K and IW=(C−1)·S+K. The weight address is ((`om`·N+`im`)·K+`ky`)·K+`kx`. The output address is (`om`·R+`r`)·C+`c`. All addresses are in range.
- R5: Each step adds the signed product of the 8-bit weight and the 8-bit pixel to the signed 24-bit output word. A sweep therefore leaves old value + convolution sum in every output word.
- R6: A write to the output memory that was issued in the previous cycle is forwarded to the following step when both use the same address, so back-to-back accumulations into one word are never lost.
- R7: One step is issued per cycle with no gaps. Let T = M·N·R·C·K·K, and call the rising edge that accepts start edge 0. `done` is high in the cycle after edge T+1.
- R8: `busy` rises on the edge that accepts start and falls on the edge that raises `done`. `done` is high for exactly one cycle.
- R9: A start pulse while `busy` is high is ignored: the sweep is neither restarted nor lengthened.
- R10: With all pixels and weights at −128, the 24-bit sums do not overflow, and they do not overflow for two sweeps in a row.
- R11: With stride 2, the input window of each output element steps by two pixels in both directions.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Single-cycle sweep request |
| busy | output | 1 | Sweep in progress |
| done | output | 1 | One-cycle pulse after the last write-back |
| in_rd_en | output | 1 | Input-map read enable |
| in_rd_addr | output | IF_AW | Input-map read address |
| in_rd_data | input | 8 | Input pixel, one cycle after the address |
| wt_rd_en | output | 1 | Weight read enable |
| wt_rd_addr | output | WT_AW | Weight read address |
| wt_rd_data | input | 8 | Weight, one cycle after the address |
| acc_rd_en | output | 1 | Output-memory read enable |
| acc_rd_addr | output | OF_AW | Output-memory read address |
| acc_rd_data | input | 24 | Stored partial sum, one cycle after the address |
| acc_wr_en | output | 1 | Output-memory write enable |
| acc_wr_addr | output | OF_AW | Output-memory write address |
| acc_wr_data | output | 24 | Updated partial sum |

## Verification
The sweep is run with four data patterns. A small ramp shows up misplaced input or weight addresses, because every tap carries a different value. All −128 operands drive the largest positive sums and show whether the sums stay within the word. Alternating extremes separate sign handling from magnitude. A hashed pattern catches transposed kernel indices that symmetric data would hide. A second run without clearing the output memory checks that sums are read and added rather than overwritten. A second configuration with stride 2 and a partial last tile checks window spacing and the tile bound. The order of write addresses is compared step by step against a loop nest in the bench, and cycle counts show whether the pipeline stalls or restarts.

// File: rtl/conv_pkg.sv
package conv_pkg;
  localparam int PIX_W = 8;
  localparam int ACC_W = 24;
  localparam int PRD_W = 2 * PIX_W;

  typedef logic signed [PIX_W-1:0] pix_t;
  typedef logic signed [PRD_W-1:0] prod_t;
  typedef logic signed [ACC_W-1:0] acc_t;

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  function automatic int awidth(input int depth);
    return (depth > 1) ? $clog2(depth) : 1;
  endfunction
endpackage

// File: rtl/conv_loop_seq.sv
module conv_loop_seq #(
  parameter int M     = 2,
  parameter int N     = 2,
  parameter int R     = 5,
  parameter int C     = 4,
  parameter int K     = 3,
  parameter int S     = 1,
  parameter int TR    = 2,
  parameter int IF_AW = 7,
  parameter int WT_AW = 6,
  parameter int OF_AW = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             wb_last,
  output logic             busy,
  output logic             issue_v,
  output logic             issue_last,
  output logic [IF_AW-1:0] if_addr,
  output logic [WT_AW-1:0] wt_addr,
  output logic [OF_AW-1:0] of_addr
);
  import conv_pkg::*;

  localparam int IH    = (R - 1) * S + K;
  localparam int IW    = (C - 1) * S + K;
  localparam int IF_DEPTH = N * IH * IW;
  localparam int MAXD  = imax(imax(imax(M, N), imax(R + TR, C)), K);
  localparam int CW    = $clog2(MAXD + 1) + 1;

  typedef struct packed {
    logic [CW-1:0] om;
    logic [CW-1:0] im;
    logic [CW-1:0] ts;
    logic [CW-1:0] c;
    logic [CW-1:0] r;
    logic [CW-1:0] ky;
    logic [CW-1:0] kx;
  } idx_t;

  idx_t q, n;
  logic busy_q, busy_n;
  logic fin_q, fin_n;

  int om_i, im_i, ts_i, c_i, r_i, ky_i, kx_i, row_lim;
  logic kx_end, ky_end, r_end, c_end, ts_end, im_end, om_end, last_step;

  always_comb begin
    om_i = int'(q.om);
    im_i = int'(q.im);
    ts_i = int'(q.ts);
    c_i  = int'(q.c);
    r_i  = int'(q.r);
    ky_i = int'(q.ky);
    kx_i = int'(q.kx);
    row_lim = (ts_i + TR < R) ? (ts_i + TR) : R;
    kx_end = (kx_i == K - 1);
    ky_end = (ky_i == K - 1);
    r_end  = (r_i == row_lim - 1);
    c_end  = (c_i == C - 1);
    ts_end = (ts_i + TR >= R);
    im_end = (im_i == N - 1);
    om_end = (om_i == M - 1);
    last_step = kx_end && ky_end && r_end && c_end && ts_end && im_end && om_end;
  end

  assign issue_v    = busy_q && !fin_q;
  assign issue_last = issue_v && last_step;
  assign busy       = busy_q;

  assign if_addr = IF_AW'(im_i * IH * IW + (S * r_i + ky_i) * IW + S * c_i + kx_i);
  assign wt_addr = WT_AW'(((om_i * N + im_i) * K + ky_i) * K + kx_i);
  assign of_addr = OF_AW'((om_i * R + r_i) * C + c_i);

  // next-state: nested counter advance
  always_comb begin
    n      = q;
    busy_n = busy_q;
    fin_n  = fin_q;
    if (!busy_q) begin
      if (start) begin
        busy_n = 1'b1;
        fin_n  = 1'b0;
        n      = '0;
      end
    end else begin
      if (issue_v) begin
        if (!kx_end) n.kx = q.kx + CW'(1);
        else begin
          n.kx = '0;
          if (!ky_end) n.ky = q.ky + CW'(1);
          else begin
            n.ky = '0;
            if (!r_end) n.r = q.r + CW'(1);
            else begin
              n.r = q.ts;
              if (!c_end) n.c = q.c + CW'(1);
              else begin
                n.c = '0;
                if (!ts_end) begin
                  n.ts = q.ts + CW'(TR);
                  n.r  = q.ts + CW'(TR);
                end else begin
                  n.ts = '0;
                  n.r  = '0;
                  if (!im_end) n.im = q.im + CW'(1);
                  else begin
                    n.im = '0;
                    if (!om_end) n.om = q.om + CW'(1);
                    else begin
                      n.om  = '0;
                      fin_n = 1'b1;
                    end
                  end
                end
              end
            end
          end
        end
      end
      if (wb_last) busy_n = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q      <= '0;
      busy_q <= 1'b0;
      fin_q  <= 1'b0;
    end else begin
      q      <= n;
      busy_q <= busy_n;
      fin_q  <= fin_n;
    end
  end

  // R7: steps are issued back to back until the last one
  p_issue_run_r7: assert property (@(posedge clk) disable iff (!rst_n)
    issue_v && !issue_last |=> issue_v);

  // R4: input address stays inside the input memory
  p_addr_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
    issue_v |-> (int'(if_addr) < IF_DEPTH));

  // R9: a start during a sweep does not rewind the nest
  p_restart_ignored_r9: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q && start && issue_v && !issue_last |=> (q != '0));

  // R8: busy holds until the final write-back
  p_busy_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q && !wb_last |=> busy_q);
endmodule

// File: rtl/conv_mac_pipe.sv
module conv_mac_pipe #(
  parameter int OF_AW = 6
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                issue_v,
  input  logic                issue_last,
  input  logic [OF_AW-1:0]    issue_addr,
  input  conv_pkg::pix_t      in_pix,
  input  conv_pkg::pix_t      wt_pix,
  input  conv_pkg::acc_t      acc_old,
  output logic                wr_en,
  output logic [OF_AW-1:0]    wr_addr,
  output conv_pkg::acc_t      wr_data,
  output logic                wb_last,
  output logic                done
);
  import conv_pkg::*;

  logic             v1_q, last1_q;
  logic [OF_AW-1:0] a1_q;
  logic             pv_q;
  logic [OF_AW-1:0] pa_q;
  acc_t             psum_q;
  logic             done_q;

  prod_t prod;
  acc_t  base, sum;
  logic  fwd;

  always_comb begin
    prod = prod_t'(in_pix) * prod_t'(wt_pix);
    fwd  = pv_q && (pa_q == a1_q);
    base = fwd ? psum_q : acc_old;
    sum  = base + acc_t'(prod);
  end

  assign wr_en   = v1_q;
  assign wr_addr = a1_q;
  assign wr_data = sum;
  assign wb_last = v1_q && last1_q;
  assign done    = done_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      v1_q    <= 1'b0;
      last1_q <= 1'b0;
      a1_q    <= '0;
      pv_q    <= 1'b0;
      pa_q    <= '0;
      psum_q  <= '0;
      done_q  <= 1'b0;
    end else begin
      v1_q   <= issue_v;
      pv_q   <= v1_q;
      done_q <= v1_q && last1_q;
      if (issue_v) begin
        a1_q    <= issue_addr;
        last1_q <= issue_last;
      end
      if (v1_q) begin
        pa_q   <= a1_q;
        psum_q <= sum;
      end
    end
  end

  // R10: sum keeps the sign of same-signed operands
  p_no_overflow_r10: assert property (@(posedge clk) disable iff (!rst_n)
    v1_q && (base[ACC_W-1] == prod[PRD_W-1]) |-> (sum[ACC_W-1] == base[ACC_W-1]));

  // R6: consecutive writes to one word chain through the previous result
  p_forward_r6: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && $past(wr_en) && (wr_addr == $past(wr_addr))
      |-> (wr_data == $past(wr_data) + acc_t'(prod)));

  // R8: done is a single-cycle pulse
  p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
endmodule

// File: rtl/conv_tile_engine.sv
module conv_tile_engine #(
  parameter int M  = 2,
  parameter int N  = 2,
  parameter int R  = 5,
  parameter int C  = 4,
  parameter int K  = 3,
  parameter int S  = 1,
  parameter int TR = 2,
  localparam int IH       = (R - 1) * S + K,
  localparam int IW       = (C - 1) * S + K,
  localparam int IF_DEPTH = N * IH * IW,
  localparam int WT_DEPTH = M * N * K * K,
  localparam int OF_DEPTH = M * R * C,
  localparam int IF_AW    = conv_pkg::awidth(IF_DEPTH),
  localparam int WT_AW    = conv_pkg::awidth(WT_DEPTH),
  localparam int OF_AW    = conv_pkg::awidth(OF_DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  output logic              busy,
  output logic              done,
  output logic              in_rd_en,
  output logic [IF_AW-1:0]  in_rd_addr,
  input  logic [7:0]        in_rd_data,
  output logic              wt_rd_en,
  output logic [WT_AW-1:0]  wt_rd_addr,
  input  logic [7:0]        wt_rd_data,
  output logic              acc_rd_en,
  output logic [OF_AW-1:0]  acc_rd_addr,
  input  logic [23:0]       acc_rd_data,
  output logic              acc_wr_en,
  output logic [OF_AW-1:0]  acc_wr_addr,
  output logic [23:0]       acc_wr_data
);
  import conv_pkg::*;

  logic             issue_v, issue_last, wb_last;
  logic [OF_AW-1:0] of_addr;
  acc_t             wr_sum;

  conv_loop_seq #(
    .M(M), .N(N), .R(R), .C(C), .K(K), .S(S), .TR(TR),
    .IF_AW(IF_AW), .WT_AW(WT_AW), .OF_AW(OF_AW)
  ) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .wb_last    (wb_last),
    .busy       (busy),
    .issue_v    (issue_v),
    .issue_last (issue_last),
    .if_addr    (in_rd_addr),
    .wt_addr    (wt_rd_addr),
    .of_addr    (of_addr)
  );

  assign in_rd_en    = issue_v;
  assign wt_rd_en    = issue_v;
  assign acc_rd_en   = issue_v;
  assign acc_rd_addr = of_addr;

  conv_mac_pipe #(.OF_AW(OF_AW)) u_mac (
    .clk        (clk),
    .rst_n      (rst_n),
    .issue_v    (issue_v),
    .issue_last (issue_last),
    .issue_addr (of_addr),
    .in_pix     (pix_t'(in_rd_data)),
    .wt_pix     (pix_t'(wt_rd_data)),
    .acc_old    (acc_t'(acc_rd_data)),
    .wr_en      (acc_wr_en),
    .wr_addr    (acc_wr_addr),
    .wr_data    (wr_sum),
    .wb_last    (wb_last),
    .done       (done)
  );

  assign acc_wr_data = 24'(wr_sum);

  // R5: every read of a partial sum is written back one cycle later to the same word
  p_wr_after_rd_r5: assert property (@(posedge clk) disable iff (!rst_n)
    acc_rd_en |=> acc_wr_en && (acc_wr_addr == $past(acc_rd_addr)));
endmodule

// File: tb/tb_conv_tile_engine.sv
module tb_conv_harness #(
  parameter int M  = 2,
  parameter int N  = 2,
  parameter int R  = 5,
  parameter int C  = 4,
  parameter int K  = 3,
  parameter int S  = 1,
  parameter int TR = 2,
  parameter string TAG = "cfg",
  parameter string RES_REQ = "R5"
) (
  input  logic clk,
  input  logic rst_n,
  output logic fin,
  output int   n_run,
  output int   n_fail
);
  localparam int IH = (R - 1) * S + K;
  localparam int IW = (C - 1) * S + K;
  localparam int IF_DEPTH = N * IH * IW;
  localparam int WT_DEPTH = M * N * K * K;
  localparam int OF_DEPTH = M * R * C;
  localparam int IF_AW = (IF_DEPTH > 1) ? $clog2(IF_DEPTH) : 1;
  localparam int WT_AW = (WT_DEPTH > 1) ? $clog2(WT_DEPTH) : 1;
  localparam int OF_AW = (OF_DEPTH > 1) ? $clog2(OF_DEPTH) : 1;
  localparam int T = M * N * R * C * K * K;

  typedef struct packed { int pat; bit mid; } vec_t;
  localparam vec_t VEC [4] = '{
    '{pat: 0, mid: 1'b0},
    '{pat: 1, mid: 1'b0},
    '{pat: 2, mid: 1'b1},
    '{pat: 3, mid: 1'b0}
  };

  logic start, busy, done;
  logic in_en, wt_en, acc_rd_en, acc_wr_en;
  logic [IF_AW-1:0] in_addr;
  logic [WT_AW-1:0] wt_addr;
  logic [OF_AW-1:0] acc_rd_addr, acc_wr_addr;
  logic [7:0] in_q, wt_q;
  logic [23:0] acc_q, acc_wr_data;
  logic signed [23:0] outm [OF_DEPTH];
  logic clr;
  int pat;
  int exp_addr [T];
  int wr_cnt, ord_err, base_cnt;

  conv_tile_engine #(.M(M), .N(N), .R(R), .C(C), .K(K), .S(S), .TR(TR)) dut (
    .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
    .in_rd_en(in_en), .in_rd_addr(in_addr), .in_rd_data(in_q),
    .wt_rd_en(wt_en), .wt_rd_addr(wt_addr), .wt_rd_data(wt_q),
    .acc_rd_en(acc_rd_en), .acc_rd_addr(acc_rd_addr), .acc_rd_data(acc_q),
    .acc_wr_en(acc_wr_en), .acc_wr_addr(acc_wr_addr), .acc_wr_data(acc_wr_data)
  );

  function automatic int pv(input int p, input int kind, input int idx);
    case (p)
      0: return ((idx * 3 + kind * 5) % 17) - 8;
      1: return -128;
      2: return (((idx + kind) % 2) == 1) ? 127 : -128;
      default: return ((idx * 37 + kind * 91 + 13) % 256) - 128;
    endcase
  endfunction

  function automatic int refv(input int om, input int r, input int c);
    int acc = 0;
    for (int im = 0; im < N; im++)
      for (int ky = 0; ky < K; ky++)
        for (int kx = 0; kx < K; kx++)
          acc += pv(pat, 1, ((om * N + im) * K + ky) * K + kx) *
                 pv(pat, 0, im * IH * IW + (S * r + ky) * IW + S * c + kx);
    return acc;
  endfunction

  // memory models: one-cycle read, read-before-write
  always @(posedge clk) begin
    if (in_en) in_q <= 8'(pv(pat, 0, int'(in_addr)));
    if (wt_en) wt_q <= 8'(pv(pat, 1, int'(wt_addr)));
    if (acc_rd_en) acc_q <= outm[acc_rd_addr];
    if (clr) begin
      for (int k = 0; k < OF_DEPTH; k++) outm[k] <= '0;
    end else if (acc_wr_en) begin
      outm[acc_wr_addr] <= acc_wr_data;
    end
  end

  // write order monitor (R2)
  initial begin wr_cnt = 0; ord_err = 0; end
  always @(posedge clk) begin
    if (rst_n && acc_wr_en) begin
      if ((wr_cnt - base_cnt) >= T || int'(acc_wr_addr) != exp_addr[wr_cnt - base_cnt])
        ord_err = ord_err + 1;
      wr_cnt = wr_cnt + 1;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0d expected=%0d", TAG, req, act, exp);
    end
  endtask

  task automatic run(input int p, input bit do_clr, input bit mid, input int mult);
    int cnt, oerr0;
    pat = p;
    if (do_clr) begin
      @(negedge clk) clr = 1'b1;
      @(negedge clk) clr = 1'b0;
    end
    base_cnt = wr_cnt;
    oerr0 = ord_err;
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    cnt = 1;
    chk(busy == 1'b1, "R8 busy after start", int'(busy), 1);
    while (!done && cnt < T + 50) begin
      @(negedge clk);
      cnt++;
      start = (mid && cnt == 5);
    end
    start = 1'b0;
    chk(cnt == T + 2, "R7 latency", cnt, T + 2);
    chk(busy == 1'b0, "R8 busy low with done", int'(busy), 0);
    @(negedge clk);
    chk(done == 1'b0, "R8 done one cycle", int'(done), 0);
    chk(ord_err == oerr0 && wr_cnt - base_cnt == T, "R2 R3 write order",
        wr_cnt - base_cnt, T);
    if (mid) chk(wr_cnt - base_cnt == T, "R9 restart ignored", wr_cnt - base_cnt, T);
    for (int om = 0; om < M; om++)
      for (int r = 0; r < R; r++)
        for (int c = 0; c < C; c++) begin
          int e = mult * refv(om, r, c);
          int a = int'(outm[(om * R + r) * C + c]);
          chk(a == e, {RES_REQ, " R4 R6 result"}, a, e);
        end
  endtask

  initial begin
    int k;
    fin = 1'b0; n_run = 0; n_fail = 0;
    start = 1'b0; clr = 1'b0; pat = 0; base_cnt = 0;
    k = 0;
    for (int om = 0; om < M; om++)
      for (int im = 0; im < N; im++)
        for (int ts = 0; ts < R; ts += TR)
          for (int c = 0; c < C; c++)
            for (int r = ts; r < ((ts + TR < R) ? ts + TR : R); r++)
              for (int ky = 0; ky < K; ky++)
                for (int kx = 0; kx < K; kx++) begin
                  exp_addr[k] = (om * R + r) * C + c;
                  k++;
                end
    @(negedge clk);
    chk(!busy && !done && !in_en && !wt_en && !acc_rd_en && !acc_wr_en,
        "R1 reset state", int'(busy), 0);
    wait (rst_n);
    @(negedge clk);
    chk(!busy && !done && !acc_wr_en, "R1 after release", int'(done), 0);
    foreach (VEC[v]) run(VEC[v].pat, 1'b1, VEC[v].mid, 1);
    // directed: second sweep without clearing accumulates (R5, R10 with pattern 1)
    run(1, 1'b1, 1'b0, 1);
    run(1, 1'b0, 1'b0, 2);
    fin = 1'b1;
  end
endmodule

module tb_conv_tile_engine;
  logic clk, rst_n;
  logic fin0, fin1;
  int run0, fail0, run1, fail1;
  int cyc, wd_fail;

  initial clk = 1'b0;
  always #2 clk = ~clk;

  tb_conv_harness #(.M(2), .N(2), .R(5), .C(4), .K(3), .S(1), .TR(2),
                    .TAG("s1"), .RES_REQ("R5 R3 R10")) h_s1 (
    .clk(clk), .rst_n(rst_n), .fin(fin0), .n_run(run0), .n_fail(fail0));

  tb_conv_harness #(.M(1), .N(2), .R(3), .C(3), .K(3), .S(2), .TR(2),
                    .TAG("s2"), .RES_REQ("R11 R5 R3")) h_s2 (
    .clk(clk), .rst_n(rst_n), .fin(fin1), .n_run(run1), .n_fail(fail1));

  initial begin
    rst_n = 1'b0;
    wd_fail = 0;
    cyc = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    while (!(fin0 && fin1) && cyc < 150000) begin
      @(negedge clk);
      cyc++;
    end
    if (!(fin0 && fin1)) begin
      wd_fail = 1;
      $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
    end
    $display("[TB] %0d tests run, %0d failed", run0 + run1 + wd_fail,
             fail0 + fail1 + wd_fail);
    $finish;
  end
endmodule